// File: doc/BRIEF.md
# Event-Based Branch Alert Dispatcher

This block takes the single-cycle alert pulse from a performance monitor and decides how it reaches software. The alert can become an event-based branch, which user code handles directly. Otherwise it falls through to an ordinary performance interrupt. The branch is allowed only when three enable conditions hold: the monitor's event-based enable and the status register's global and monitor-event enables. The facility must also be granted at both the supervisor and the hypervisor level.

The block owns the three status bits it acts on: global enable, monitor-event enable and occurred. An accepted event sets the occurred bit and clears the global enable. The next step depends on privilege. In user (problem) state the block issues an immediate one-cycle exception strobe. In any other state it queues a pending flag, and that flag turns into the same strobe once the processor is back in user state. Software reloads the three status bits through a single write strobe. All outputs are registered.

Top module: `ebb_alert_dispatch`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge.
- R2: An alert is a candidate only if `mon_ebb_en`, `st_ge` and `st_pme` are all 1 on the cycle the alert is sampled. If any of them is 0, the alert sets no occurred bit, issues no strobe and queues nothing.
- R3: A candidate is accepted only if `fac_sup_en` and `fac_hyp_en` are both 1. Otherwise it is treated as not accepted.
- R4: An accepted alert sets `st_occ` to 1 after the same edge.
- R5: An accepted alert with `user_mode`=1 drives `ebb_now` high for exactly the one cycle after the edge, and `ebb_pending` stays 0.
- R6: An accepted alert with `user_mode`=0 sets `ebb_pending` to 1 and gives no strobe.
- R7: While `ebb_pending`=1, the first edge with `user_mode`=1 raises `ebb_now` for one cycle and clears `ebb_pending`.
- R8: An accepted alert clears `st_ge` after the same edge, so later alerts are refused until software writes it back to 1.
- R9: An alert that is not accepted drives `pmi_req` high for one cycle if `ext_int_en`=1, and leaves it low if `ext_int_en`=0. `pmi_req` is low in every cycle that follows no alert.
- R10: `st_occ` stays 1 until a write (`st_wr`=1) loads it with 0.
- R11: `st_wr` loads `st_ge`, `st_pme` and `st_occ` from `wr_ge`, `wr_pme` and `wr_occ`. If an accepted alert arrives in the same cycle, the hardware result wins: occurred goes to 1 and global enable goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alert | input | 1 | Performance monitor alert pulse |
| mon_ebb_en | input | 1 | Monitor control event-based enable |
| fac_sup_en | input | 1 | Supervisor facility enable for event-based branches |
| fac_hyp_en | input | 1 | Hypervisor facility enable for event-based branches |
| user_mode | input | 1 | Processor is in problem (user) state |
| ext_int_en | input | 1 | External-interrupt enable |
| st_wr | input | 1 | Software write strobe for the status bits |
| wr_ge | input | 1 | Written value of global enable |
| wr_pme | input | 1 | Written value of monitor-event enable |
| wr_occ | input | 1 | Written value of occurred bit |
| ebb_now | output | 1 | One-cycle event-based exception strobe |
| ebb_pending | output | 1 | Queued event-based interrupt |
| pmi_req | output | 1 | One-cycle ordinary performance interrupt request |
| st_ge | output | 1 | Status global enable |
| st_pme | output | 1 | Status monitor-event enable |
| st_occ | output | 1 | Status monitor-event occurred |

## Verification
The bench sweeps all 128 combinations of the three enables, the two facility grants, privilege state and external-interrupt enable. A conjunction with a term missing would produce a branch or set occurred where the sweep expects an ordinary interrupt. A design that swapped the privilege paths would strobe in supervisor state or queue in user state. If the queued flag were never released or never cleared, the second phase of each vector would show it, because that phase raises user state. The bench also writes the status bits in the same cycle as an accepted alert, which catches a design that lets the software value override the hardware result. It then checks that occurred holds over idle cycles, which catches a design that lets the bit decay.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
  typedef struct packed {
    logic ge;
    logic pme;
    logic occ;
  } ebb_stat_t;
endpackage

// File: rtl/ebb_qualify.sv
module ebb_qualify (
  input  logic alert,
  input  logic mon_ebb_en,
  input  logic ge,
  input  logic pme,
  input  logic fac_sup_en,
  input  logic fac_hyp_en,
  output logic take,
  output logic fall
);
  logic cand;
  logic granted;

  always_comb begin
    cand    = mon_ebb_en & ge & pme;
    granted = cand & fac_sup_en & fac_hyp_en;
    take    = alert & granted;
    fall    = alert & ~granted;
  end
endmodule

// File: rtl/ebb_status_reg.sv
module ebb_status_reg
  import ebb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  ebb_stat_t wdata,
  input  logic      take,
  output ebb_stat_t q
);
  ebb_stat_t nxt;

  always_comb begin
    nxt = wr ? wdata : q;
    if (take) begin
      nxt.occ = 1'b1;
      nxt.ge  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R4
  occ_set_chk: assert property (@(posedge clk) disable iff (rst) take |=> q.occ);
  // R8
  ge_clear_chk: assert property (@(posedge clk) disable iff (rst) take |=> !q.ge);
  // R10
  occ_sticky_chk: assert property (@(posedge clk) disable iff (rst) (q.occ && !wr) |=> q.occ);
endmodule

// File: rtl/ebb_deliver.sv
module ebb_deliver (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic fall,
  input  logic user_mode,
  input  logic ext_int_en,
  output logic ebb_now,
  output logic ebb_pending,
  output logic pmi_req
);
  logic release_q;

  always_comb release_q = ebb_pending & user_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ebb_now     <= 1'b0;
      ebb_pending <= 1'b0;
      pmi_req     <= 1'b0;
    end else begin
      ebb_now <= (take & user_mode) | release_q;
      if (take & ~user_mode) ebb_pending <= 1'b1;
      else if (release_q)    ebb_pending <= 1'b0;
      pmi_req <= fall & ext_int_en;
    end
  end

  // R5
  user_strobe_chk: assert property (@(posedge clk) disable iff (rst) (take && user_mode) |=> ebb_now);
  // R6
  queue_chk: assert property (@(posedge clk) disable iff (rst) (take && !user_mode) |=> ebb_pending);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst) (ebb_pending && user_mode) |=> (ebb_now && !ebb_pending));
  // R9
  pmi_idle_chk: assert property (@(posedge clk) disable iff (rst) !fall |=> !pmi_req);
endmodule

// File: rtl/ebb_alert_dispatch.sv
module ebb_alert_dispatch
  import ebb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic alert,
  input  logic mon_ebb_en,
  input  logic fac_sup_en,
  input  logic fac_hyp_en,
  input  logic user_mode,
  input  logic ext_int_en,
  input  logic st_wr,
  input  logic wr_ge,
  input  logic wr_pme,
  input  logic wr_occ,
  output logic ebb_now,
  output logic ebb_pending,
  output logic pmi_req,
  output logic st_ge,
  output logic st_pme,
  output logic st_occ
);
  ebb_stat_t stat;
  ebb_stat_t wdata;
  logic      take;
  logic      fall;

  always_comb begin
    wdata.ge  = wr_ge;
    wdata.pme = wr_pme;
    wdata.occ = wr_occ;
  end

  ebb_qualify u_qual (
    .alert      (alert),
    .mon_ebb_en (mon_ebb_en),
    .ge         (stat.ge),
    .pme        (stat.pme),
    .fac_sup_en (fac_sup_en),
    .fac_hyp_en (fac_hyp_en),
    .take       (take),
    .fall       (fall)
  );

  ebb_status_reg u_stat (
    .clk   (clk),
    .rst   (rst),
    .wr    (st_wr),
    .wdata (wdata),
    .take  (take),
    .q     (stat)
  );

  ebb_deliver u_dlv (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .fall        (fall),
    .user_mode   (user_mode),
    .ext_int_en  (ext_int_en),
    .ebb_now     (ebb_now),
    .ebb_pending (ebb_pending),
    .pmi_req     (pmi_req)
  );

  always_comb begin
    st_ge  = stat.ge;
    st_pme = stat.pme;
    st_occ = stat.occ;
  end

  // R2
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (alert && !(mon_ebb_en && st_ge && st_pme) && !st_wr && !st_occ) |=> !st_occ);
  // R3
  facility_chk: assert property (@(posedge clk) disable iff (rst)
    (alert && !(fac_sup_en && fac_hyp_en) && !ebb_pending) |=> (!ebb_now && !ebb_pending));
endmodule

// File: tb/test_ebb_alert_dispatch.sv
module test_ebb_alert_dispatch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alert = 0, mon_ebb_en = 0, fac_sup_en = 0, fac_hyp_en = 0;
  logic user_mode = 0, ext_int_en = 0, st_wr = 0, wr_ge = 0, wr_pme = 0, wr_occ = 0;
  logic ebb_now, ebb_pending, pmi_req, st_ge, st_pme, st_occ;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ebb_alert_dispatch i_ebb_alert_dispatch (
    .clk(clk), .rst(rst), .alert(alert), .mon_ebb_en(mon_ebb_en),
    .fac_sup_en(fac_sup_en), .fac_hyp_en(fac_hyp_en), .user_mode(user_mode),
    .ext_int_en(ext_int_en), .st_wr(st_wr), .wr_ge(wr_ge), .wr_pme(wr_pme),
    .wr_occ(wr_occ), .ebb_now(ebb_now), .ebb_pending(ebb_pending),
    .pmi_req(pmi_req), .st_ge(st_ge), .st_pme(st_pme), .st_occ(st_occ)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1", "ebb_now", ebb_now, 1'b0);
    chk("R1", "ebb_pending", ebb_pending, 1'b0);
    chk("R1", "pmi_req", pmi_req, 1'b0);
    chk("R1", "st_ge", st_ge, 1'b0);
    chk("R1", "st_pme", st_pme, 1'b0);
    chk("R1", "st_occ", st_occ, 1'b0);
    rst = 0;
    step();

    for (int v = 0; v < 128; v++) begin
      logic e, g, p, s, h, u, x, ok;
      {e, g, p, s, h, u, x} = v[6:0];
      ok = e & g & p & s & h;
      // load the status bits, user state off
      st_wr = 1; wr_ge = g; wr_pme = p; wr_occ = 0; user_mode = 0;
      step();
      st_wr = 0;
      alert = 1; mon_ebb_en = e; fac_sup_en = s; fac_hyp_en = h;
      user_mode = u; ext_int_en = x;
      step();
      alert = 0;
      // R2 R3 R4: occurred only when the whole conjunction holds
      chk("R4", "st_occ", st_occ, ok);
      chk("R8", "st_ge", st_ge, g & ~ok);
      chk("R11", "st_pme", st_pme, p);
      chk("R5", "ebb_now", ebb_now, ok & u);
      chk("R6", "ebb_pending", ebb_pending, ok & ~u);
      chk("R9", "pmi_req", pmi_req, ~ok & x);
      // phase two: enter user state
      user_mode = 1;
      step();
      chk("R7", "ebb_now release", ebb_now, ok & ~u);
      chk("R7", "ebb_pending cleared", ebb_pending, 1'b0);
      chk("R9", "pmi_req idle", pmi_req, 1'b0);
      step();
      chk("R5", "ebb_now one cycle", ebb_now, 1'b0);
      chk("R10", "st_occ held", st_occ, ok);
    end

    // R8: with ge cleared by an accepted event, a second alert is refused
    st_wr = 1; wr_ge = 1; wr_pme = 1; wr_occ = 0; user_mode = 1;
    mon_ebb_en = 1; fac_sup_en = 1; fac_hyp_en = 1; ext_int_en = 1;
    step(); st_wr = 0;
    alert = 1; step(); alert = 0;
    chk("R8", "first accepted", ebb_now, 1'b1);
    alert = 1; step(); alert = 0;
    chk("R8", "second refused strobe", ebb_now, 1'b0);
    chk("R8", "second to pmi", pmi_req, 1'b1);

    // R10: occurred sticky over idle cycles, cleared by write
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R10", "st_occ sticky", st_occ, 1'b1);
    end
    st_wr = 1; wr_ge = 0; wr_pme = 0; wr_occ = 0;
    step(); st_wr = 0;
    chk("R10", "st_occ cleared", st_occ, 1'b0);

    // R11: write and accepted alert in the same cycle
    st_wr = 1; wr_ge = 1; wr_pme = 1; wr_occ = 0;
    step();
    wr_ge = 1; wr_pme = 0; wr_occ = 0; alert = 1;
    step(); st_wr = 0; alert = 0;
    chk("R11", "st_occ hw wins", st_occ, 1'b1);
    chk("R11", "st_ge hw wins", st_ge, 1'b0);
    chk("R11", "st_pme written", st_pme, 1'b0);

    // R1: reset mid-run clears a queued flag
    st_wr = 1; wr_ge = 1; wr_pme = 1; wr_occ = 0; user_mode = 0;
    step(); st_wr = 0;
    alert = 1; step(); alert = 0;
    chk("R6", "queued", ebb_pending, 1'b1);
    rst = 1; step(); rst = 0;
    chk("R1", "pending after reset", ebb_pending, 1'b0);
    chk("R1", "st_occ after reset", st_occ, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule